// File: doc/BRIEF.md
# Static Memory Bank Timing Sequencer

This block runs one bank of an external asynchronous memory or peripheral bus. An internal requester hands it one access at a time: an address, a read or write flag and write data. The block then drives the external address lines, an active-low chip select and an active-low read strobe or write strobe. Each of the gaps between these edges has its own programmable cycle count. Read data comes back on a one-cycle valid pulse for every beat. A one-cycle done pulse marks the end of the access.

A configuration register holds the six timing counts, the bus width and the page setting. The bus width is either 8 or 16 bits. The page setting is either one beat or a four-beat read burst. The register is copied into the sequencer when a request is accepted. Writes to it are dropped while an access is in flight.

The request side is valid/ready: `req_ready` is high only while the sequencer is idle, and a request is taken on the edge where both are high. A requester may hold `req_valid` for as long as it likes. Read-data and done pulses carry no back-pressure: the requester must take each one in the cycle it appears. All external strobes, address and data pins come from flip-flops.

Top module: `smem_seq`

## Requirements
- R1: After reset, `mem_cs_n`, `mem_oe_n` and `mem_we_n` are high, `mem_dout_en`, `busy`, `done` and `rd_valid` are low, and `req_ready` is high.
- R2: The access runs through its phases in a fixed order. Counting from the first cycle after acceptance: chip select stays high for `cfg_a2c` cycles. It is then low with the strobe still high for `cfg_c2s` cycles. The strobe is then low for `cfg_strobe`+1 cycles. After that it is high with chip select still low for `cfg_s2c` cycles. Chip select is then high with `busy` still set for `cfg_c2a` cycles.
- R3: A timing count of zero removes its phase entirely. With every count at zero, an access is a single cycle of strobe and chip select low, followed by the done cycle.
- R4: A write pulls `mem_we_n` low in the strobe phase and never pulls `mem_oe_n` low. `mem_dout_en` is high and `mem_dout` carries the write data in every strobe cycle.
- R5: Read data is sampled from `mem_din` on the last strobe cycle of a beat. It appears on `rd_data` with a one-cycle `rd_valid` pulse in the cycle that follows.
- R6: With `cfg_wide`=0 (8-bit bus), bits 15:8 of `rd_data` read as zero and bits 15:8 of `mem_dout` are driven to zero. With `cfg_wide`=1, all 16 bits pass.
- R7: With `cfg_burst`=1, a read performs four beats. The strobe stays low throughout. Address bits 1:0 step through 0,1,2,3 and the upper address bits stay those of the request. The first beat lasts `cfg_strobe`+1 cycles and each later beat lasts `cfg_beat`+1 cycles. Four `rd_valid` pulses are produced. A write with `cfg_burst`=1 is a single beat.
- R8: `busy` rises on the edge that accepts a request and `req_ready` is its inverse. A request presented while `busy` is high is not accepted and causes no further access.
- R9: A configuration write presented while `busy` is high is ignored. Both the current access and later ones keep the old settings.
- R10: After reset the configuration is 8-bit width, single beat, and all timing counts are zero.
- R11: `done` is a single-cycle pulse. It appears in the first cycle after the last phase, in which `busy` is already low.
- R12: `mem_cs_n` is high whenever `busy` is low, and a strobe is never low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration register (idle only) |
| cfg_a2c | input | 4 | Cycles from address valid to chip select low |
| cfg_c2s | input | 4 | Cycles from chip select low to strobe low |
| cfg_strobe | input | 5 | First-beat strobe length minus one |
| cfg_s2c | input | 4 | Cycles from strobe high to chip select high |
| cfg_c2a | input | 4 | Cycles from chip select high to address release |
| cfg_beat | input | 4 | Later page-beat length minus one |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_burst | input | 1 | 1 = four-beat page read, 0 = single beat |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse per captured read beat |
| rd_data | output | DATA_W | Captured read data |
| done | output | 1 | One-cycle pulse at end of access |
| busy | output | 1 | Access in progress |
| mem_addr | output | ADDR_W | External address |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dout | output | DATA_W | Write data to the bus |
| mem_dout_en | output | 1 | Enable for the bus data drivers |
| mem_din | input | DATA_W | Read data from the bus |

## Verification
The hardest situations to reach are those where something arrives at the edge while an access is still running. One is a second request, the other a configuration write. Both must leave the running access and the following one untouched. The bench walks every access one cycle at a time from the accepting edge and can inject a request or a configuration write at a chosen cycle of the walk. It then measures the lengths of the phases from the pin levels and compares them against the settings that should still be in force. Page bursts are checked by letting the external data follow the address. Each captured beat then shows whether the low address bits stepped in order.

// File: rtl/smem_pkg.sv
package smem_pkg;
  localparam int CNT_W      = 5;
  localparam int PAGE_BEATS = 4;
  localparam int BEAT_W     = $clog2(PAGE_BEATS);

  typedef struct packed {
    logic [3:0]       a2c;
    logic [3:0]       c2s;
    logic [CNT_W-1:0] strobe;
    logic [3:0]       s2c;
    logic [3:0]       c2a;
    logic [3:0]       beat;
    logic             wide;
    logic             burst;
  } smem_cfg_t;

  typedef enum logic [2:0] {
    PH_IDLE, PH_ASU, PH_CSU, PH_ACC, PH_PAGE, PH_CHLD, PH_AHLD
  } smem_ph_e;
endpackage

// File: rtl/smem_cfg_reg.sv
module smem_cfg_reg
  import smem_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      busy,
  input  smem_cfg_t wr_val,
  output smem_cfg_t cfg_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)              cfg_q <= '0;
    else if (wr_en && !busy) cfg_q <= wr_val;
  end

  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> $stable(cfg_q));
endmodule

// File: rtl/smem_phase_ctl.sv
module smem_phase_ctl
  import smem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              req_write,
  input  smem_cfg_t         cfg_live,
  output smem_ph_e          state_d,
  output logic [BEAT_W-1:0] beat_d,
  output logic              busy_q,
  output logic              cap,
  output logic              finish,
  output logic              wr_d,
  output logic              wide_d,
  output logic              page_d
);
  smem_ph_e          state_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BEAT_W-1:0] beat_q;
  smem_cfg_t         act_q, cur;
  logic              wr_q, adv;

  function automatic logic [CNT_W-1:0] load_of(smem_ph_e ph, smem_cfg_t c);
    case (ph)
      PH_ASU:  load_of = CNT_W'(c.a2c) - CNT_W'(1);
      PH_CSU:  load_of = CNT_W'(c.c2s) - CNT_W'(1);
      PH_ACC:  load_of = c.strobe;
      PH_PAGE: load_of = CNT_W'(c.beat);
      PH_CHLD: load_of = CNT_W'(c.s2c) - CNT_W'(1);
      PH_AHLD: load_of = CNT_W'(c.c2a) - CNT_W'(1);
      default: load_of = '0;
    endcase
  endfunction

  function automatic smem_ph_e tail_of(smem_cfg_t c);
    if (c.s2c != 4'd0)      tail_of = PH_CHLD;
    else if (c.c2a != 4'd0) tail_of = PH_AHLD;
    else                    tail_of = PH_IDLE;
  endfunction

  always_comb begin
    cur     = (state_q == PH_IDLE) ? cfg_live : act_q;
    wr_d    = (state_q == PH_IDLE) ? req_write : wr_q;
    wide_d  = cur.wide;
    page_d  = cur.burst & ~wr_d;
    state_d = state_q;
    beat_d  = beat_q;
    cnt_d   = cnt_q;
    adv     = 1'b0;
    if (state_q == PH_IDLE) begin
      if (fire) begin
        adv    = 1'b1;
        beat_d = '0;
        if (cur.a2c != 4'd0)      state_d = PH_ASU;
        else if (cur.c2s != 4'd0) state_d = PH_CSU;
        else                      state_d = PH_ACC;
      end
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end else begin
      adv = 1'b1;
      case (state_q)
        PH_ASU:  state_d = (cur.c2s != 4'd0) ? PH_CSU : PH_ACC;
        PH_CSU:  state_d = PH_ACC;
        PH_ACC, PH_PAGE: begin
          if (page_d && beat_q != BEAT_W'(PAGE_BEATS-1)) begin
            state_d = PH_PAGE;
            beat_d  = beat_q + BEAT_W'(1);
          end else begin
            state_d = tail_of(cur);
          end
        end
        PH_CHLD: state_d = (cur.c2a != 4'd0) ? PH_AHLD : PH_IDLE;
        default: state_d = PH_IDLE;
      endcase
    end
    if (adv) cnt_d = load_of(state_d, cur);
  end

  assign cap    = (state_q == PH_ACC || state_q == PH_PAGE) && cnt_q == '0;
  assign finish = (state_q != PH_IDLE) && (state_d == PH_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PH_IDLE;
      cnt_q   <= '0;
      beat_q  <= '0;
      busy_q  <= 1'b0;
      act_q   <= '0;
      wr_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      beat_q  <= beat_d;
      busy_q  <= (state_d != PH_IDLE);
      if (fire) begin
        act_q <= cfg_live;
        wr_q  <= req_write;
      end
    end
  end

  assert_page_read_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PH_PAGE) |-> (!wr_q && act_q.burst));
  assert_busy_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !busy_q);
endmodule

// File: rtl/smem_bus_drv.sv
module smem_bus_drv
  import smem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  smem_ph_e          state_d,
  input  logic [BEAT_W-1:0] beat_d,
  input  logic              wr_d,
  input  logic              wide_d,
  input  logic              page_d,
  input  logic              cap,
  input  logic              finish,
  input  logic [DATA_W-1:0] mem_din,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);
  localparam int HALF_W = DATA_W / 2;

  logic [ADDR_W-1:0] addr_q, base_now;
  logic [DATA_W-1:0] wdata_q, wdata_now;
  logic              cs_on, strobe_on;

  function automatic logic [DATA_W-1:0] narrow(logic [DATA_W-1:0] v, logic wide);
    narrow = wide ? v : {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
  endfunction

  always_comb begin
    base_now  = fire ? req_addr  : addr_q;
    wdata_now = fire ? req_wdata : wdata_q;
    strobe_on = (state_d == PH_ACC) || (state_d == PH_PAGE);
    cs_on     = strobe_on || (state_d == PH_CSU) || (state_d == PH_CHLD);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q      <= '0;
      wdata_q     <= '0;
      mem_addr    <= '0;
      mem_cs_n    <= 1'b1;
      mem_oe_n    <= 1'b1;
      mem_we_n    <= 1'b1;
      mem_dout    <= '0;
      mem_dout_en <= 1'b0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      done        <= 1'b0;
    end else begin
      if (fire) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (state_d != PH_IDLE)
        mem_addr <= page_d ? {base_now[ADDR_W-1:BEAT_W], beat_d} : base_now;
      mem_cs_n    <= ~cs_on;
      mem_oe_n    <= ~(strobe_on && !wr_d);
      mem_we_n    <= ~(strobe_on && wr_d);
      mem_dout_en <= cs_on && wr_d;
      mem_dout    <= narrow(wdata_now, wide_d);
      rd_valid    <= cap && !wr_d;
      if (cap && !wr_d) rd_data <= narrow(mem_din, wide_d);
      done        <= finish;
    end
  end

  assert_strobe_inside_cs_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_oe_n || !mem_we_n) |-> !mem_cs_n);
  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: rtl/smem_seq.sv
module smem_seq
  import smem_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_a2c,
  input  logic [3:0]        cfg_c2s,
  input  logic [4:0]        cfg_strobe,
  input  logic [3:0]        cfg_s2c,
  input  logic [3:0]        cfg_c2a,
  input  logic [3:0]        cfg_beat,
  input  logic              cfg_wide,
  input  logic              cfg_burst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              done,
  output logic              busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din
);
  smem_cfg_t         cfg_wr, cfg_q;
  smem_ph_e          state_d;
  logic [BEAT_W-1:0] beat_d;
  logic              busy_q, fire, cap, finish, wr_d, wide_d, page_d;

  assign cfg_wr    = '{a2c: cfg_a2c, c2s: cfg_c2s, strobe: cfg_strobe, s2c: cfg_s2c,
                       c2a: cfg_c2a, beat: cfg_beat, wide: cfg_wide, burst: cfg_burst};
  assign req_ready = ~busy_q;
  assign busy      = busy_q;
  assign fire      = req_valid && req_ready;

  smem_cfg_reg u_cfg (
    .clk, .rst_n, .wr_en(cfg_we), .busy(busy_q), .wr_val(cfg_wr), .cfg_q
  );

  smem_phase_ctl u_ctl (
    .clk, .rst_n, .fire, .req_write, .cfg_live(cfg_q), .state_d, .beat_d,
    .busy_q, .cap, .finish, .wr_d, .wide_d, .page_d
  );

  smem_bus_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
    .clk, .rst_n, .fire, .req_addr, .req_wdata, .state_d, .beat_d, .wr_d,
    .wide_d, .page_d, .cap, .finish, .mem_din, .mem_addr, .mem_cs_n,
    .mem_oe_n, .mem_we_n, .mem_dout, .mem_dout_en, .rd_valid, .rd_data, .done
  );

  assert_idle_cs_high_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mem_cs_n);
  assert_no_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done));
endmodule

// File: tb/smem_seq_tb.sv
`timescale 1ns/100ps
module smem_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_wide = 0, cfg_burst = 0;
  logic [3:0] cfg_a2c = 0, cfg_c2s = 0, cfg_s2c = 0, cfg_c2a = 0, cfg_beat = 0;
  logic [4:0] cfg_strobe = 0;
  logic req_valid = 0, req_write = 0, req_ready;
  logic [15:0] req_addr = 0, req_wdata = 0, rd_data, mem_addr, mem_dout, mem_din;
  logic rd_valid, done, busy, mem_cs_n, mem_oe_n, mem_we_n, mem_dout_en;

  int n_chk = 0, n_bad = 0;
  int m_pre, m_csu, m_stl, m_s2c, m_post, m_rd, m_wbad, m_oebad, m_gap, m_dbusy;
  logic [15:0] m_dat [4];

  always #2.5 clk = ~clk;

  function automatic logic [15:0] mdl(input logic [15:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0]};
  endfunction
  assign mem_din = mdl(mem_addr);

  smem_seq u_dut (.*);

  task automatic chk(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic set_cfg(input int a, c, s, h, p, b, input logic w, u);
    @(negedge clk);
    cfg_a2c = 4'(a); cfg_c2s = 4'(c); cfg_strobe = 5'(s); cfg_s2c = 4'(h);
    cfg_c2a = 4'(p); cfg_beat = 4'(b); cfg_wide = w; cfg_burst = u; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  // Walk one access cycle by cycle; optional request / config injection.
  task automatic run_txn(input logic wr, input logic [15:0] a, wd, expd,
                         input int inj_at, cfg_at);
    logic seen_cs = 0, seen_st = 0;
    m_pre = 0; m_csu = 0; m_stl = 0; m_s2c = 0; m_post = 0; m_rd = 0;
    m_wbad = 0; m_oebad = 0; m_gap = 0; m_dbusy = -1;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 0;
    for (int i = 1; i < 400; i++) begin
      if (i > 1) @(negedge clk);
      if (i == inj_at) begin req_valid = 1; req_addr = 16'hFFFF; end
      if (i == inj_at + 1) req_valid = 0;
      if (i == cfg_at) begin
        cfg_a2c = 4'd7; cfg_strobe = 5'd9; cfg_wide = 0; cfg_burst = 1; cfg_we = 1;
      end
      if (i == cfg_at + 1) cfg_we = 0;
      if (rd_valid && m_rd < 4) begin m_dat[m_rd] = rd_data; m_rd++; end
      if (done) begin m_dbusy = int'(busy); break; end
      if (busy) begin
        if (mem_cs_n) begin
          if (!seen_cs) m_pre++; else m_post++;
        end else begin
          seen_cs = 1;
          if (!mem_oe_n || !mem_we_n) begin
            if (m_s2c > 0) m_gap++;
            seen_st = 1; m_stl++;
            if (wr && (!mem_dout_en || mem_dout != expd)) m_wbad++;
            if (wr && !mem_oe_n) m_oebad++;
          end else if (!seen_st) m_csu++;
          else m_s2c++;
        end
      end
    end
    chk("R11 done seen with busy low", m_dbusy, 0);
    @(negedge clk);
    chk("R11 done single cycle", int'(done), 0);
  endtask

  task automatic shape(input string rq, input int a, c, s, h, p);
    chk({rq, " addr setup"}, m_pre, a);
    chk({rq, " cs setup"}, m_csu, c);
    chk({rq, " strobe len"}, m_stl, s);
    chk({rq, " cs hold"}, m_s2c, h);
    chk({rq, " addr hold"}, m_post, p);
  endtask

  task automatic t_reset;
    chk("R1 cs_n", int'(mem_cs_n), 1);
    chk("R1 oe_n", int'(mem_oe_n), 1);
    chk("R1 we_n", int'(mem_we_n), 1);
    chk("R1 dout_en", int'(mem_dout_en), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 ready", int'(req_ready), 1);
    chk("R1 done/rd_valid", int'(done | rd_valid), 0);
  endtask

  task automatic t_default_read;   // R10 R3 R6
    run_txn(0, 16'h34C1, 0, 0, 0, 0);
    shape("R3 zero counts", 0, 0, 1, 0, 0);
    chk("R10 single beat", m_rd, 1);
    chk("R6 8-bit read upper zero", m_dat[0], 16'h00C1);
  endtask

  task automatic t_timed_read;     // R2 R5
    set_cfg(2, 3, 4, 1, 2, 0, 1, 0);
    run_txn(0, 16'h0A17, 0, 0, 0, 0);
    shape("R2 read", 2, 3, 5, 1, 2);
    chk("R5 one rd_valid", m_rd, 1);
    chk("R5 read data", m_dat[0], mdl(16'h0A17));
  endtask

  task automatic t_write16;        // R4
    run_txn(1, 16'h0200, 16'hBEEF, 16'hBEEF, 0, 0);
    shape("R4 write", 2, 3, 5, 1, 2);
    chk("R4 write data on strobe", m_wbad, 0);
    chk("R4 oe stays high", m_oebad, 0);
    chk("R4 no read pulse", m_rd, 0);
  endtask

  task automatic t_write8;         // R6
    set_cfg(1, 1, 2, 1, 1, 0, 0, 0);
    run_txn(1, 16'h0201, 16'hBEEF, 16'h00EF, 0, 0);
    chk("R6 8-bit write upper zero", m_wbad, 0);
  endtask

  task automatic t_page_read;      // R7
    set_cfg(1, 1, 5, 1, 1, 2, 1, 1);
    run_txn(0, 16'h1237, 0, 0, 0, 0);
    shape("R7 page", 1, 1, 6 + 3 * 3, 1, 1);
    chk("R7 strobe continuous", m_gap, 0);
    chk("R7 four beats", m_rd, 4);
    for (int k = 0; k < 4; k++)
      chk("R7 beat data/address", m_dat[k], mdl(16'h1234 + 16'(k)));
    run_txn(1, 16'h1237, 16'h55AA, 16'h55AA, 0, 0);
    chk("R7 page write single beat", m_stl, 6);
  endtask

  task automatic t_busy_request;   // R8 R12
    int extra = 0;
    set_cfg(3, 2, 6, 2, 3, 0, 1, 0);
    run_txn(0, 16'h0044, 0, 0, 3, 0);
    shape("R8 unchanged access", 3, 2, 7, 2, 3);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (busy || done || !mem_cs_n) extra++;
    end
    chk("R8 busy request dropped", extra, 0);
    chk("R12 idle cs high", int'(mem_cs_n), 1);
  endtask

  task automatic t_cfg_busy;       // R9
    set_cfg(2, 1, 3, 1, 1, 0, 1, 0);
    run_txn(0, 16'h0081, 0, 0, 0, 2);
    shape("R9 in-flight", 2, 1, 4, 1, 1);
    run_txn(0, 16'h0081, 0, 0, 0, 0);
    shape("R9 next access", 2, 1, 4, 1, 1);
    chk("R9 width kept", m_dat[0], mdl(16'h0081));
  endtask

  task automatic t_max;            // R2 boundary
    set_cfg(15, 15, 31, 15, 15, 0, 1, 0);
    run_txn(0, 16'h0F0F, 0, 0, 0, 0);
    shape("R2 maximum counts", 15, 15, 32, 15, 15);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_read();
    t_timed_read();
    t_write16();
    t_write8();
    t_page_read();
    t_busy_request();
    t_cfg_busy();
    t_max();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule